// File: doc/BRIEF.md
# DFT Test Point Bank

This block wraps a group of functional nets with test points so that automatic test patterns can reach logic that scan alone cannot control or observe. It offers three kinds of point, each in a parameterised quantity: control points that can pull a net low, control points that can pull a net high, and observe points that sample a net. Every point owns one newly added flip-flop. Together these flops form a single scan chain, so the tester loads control values and unloads observed values with ordinary shift operations.

A control point sits in series with its net. While the global test-point enable is low, the net passes through untouched. While it is high and the point's flop holds 1, the net is driven to its forced constant. An observe point gates its net with the same enable and feeds the result to its flop. When scan-enable is low, the flop captures that result. Control flops keep their loaded value whenever the chain is not shifting.

Top module: `tp_bank`

## Requirements
- R1: With `tp_en` = 0, every `and_net_o[i]` equals `and_net_i[i]` and every `or_net_o[j]` equals `or_net_i[j]`, whatever the flops hold.
- R2: With `tp_en` = 1, a low-forcing point whose flop holds 1 drives 0, and one whose flop holds 0 passes its input.
- R3: With `tp_en` = 1, a high-forcing point whose flop holds 1 drives 1, and one whose flop holds 0 passes its input.
- R4: On a clock edge with `scan_en` = 0 and `tp_en` = 0, every observe flop captures 0, whatever value its net has.
- R5: On a clock edge with `scan_en` = 0 and `tp_en` = 1, every observe flop captures the current value of its net.
- R6: On each clock edge with `scan_en` = 1, the chain moves one place. `scan_in` enters chain position 0, and each position k > 0 takes the old value of position k-1.
- R7: The chain positions run in this order: low-forcing flops (position i for point i), then high-forcing flops, then observe flops. `scan_out` is the value of the last position. After NT shifts, the first bit shifted in appears at `scan_out`.
- R8: On a clock edge with `scan_en` = 0, every control flop keeps its value.
- R9: Driving `rst_n` low clears all flops to 0 at once, without a clock edge. Afterwards `scan_out` is 0 and no control point forces its net, even with `tp_en` = 1.
- R10: A group whose count parameter is 0 takes no chain position. The remaining groups close up in the order given in R7, and the output of an empty control group is tied to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the test-point flops |
| rst_n | input | 1 | Asynchronous active-low reset |
| tp_en | input | 1 | Global test-point enable |
| scan_en | input | 1 | 1 = shift the chain, 0 = hold control flops and capture observe flops |
| scan_in | input | 1 | Serial input to chain position 0 |
| and_net_i | input | AW | Original nets of the low-forcing points |
| and_net_o | output | AW | Driven nets of the low-forcing points |
| or_net_i | input | OW | Original nets of the high-forcing points |
| or_net_o | output | OW | Driven nets of the high-forcing points |
| obs_net_i | input | BW | Nets sampled by the observe points |
| scan_out | output | 1 | Serial output from the last chain position |

## Verification
A control flop holding a wrong value appears on its driven net in the same cycle that `tp_en` is high. It also appears at `scan_out` within NT shifts of an unload. A wrong observe capture or a broken chain link is never seen on the functional nets. It shows only in the serial stream, at a bit position fixed by the chain order, so the checks compare whole unloaded words bit by bit against the loaded pattern and the gated net values. Sweeping every control pattern against every net value and both enable states covers each forcing combination.

// File: rtl/tp_bank_pkg.sv
package tp_bank_pkg;
    typedef enum logic {
        CP_FORCE_LOW  = 1'b0,
        CP_FORCE_HIGH = 1'b1
    } cp_kind_e;
endpackage

// File: rtl/tp_ctrl_cell.sv
module tp_ctrl_cell
    import tp_bank_pkg::*;
#(
    parameter cp_kind_e KIND = CP_FORCE_LOW
) (
    input  logic tp_en,
    input  logic hold_q,
    input  logic net_i,
    output logic net_o
);
    logic arm;
    assign arm = tp_en & hold_q;

    generate
        if (KIND == CP_FORCE_LOW) begin : g_low
            logic pass_n;
            assign pass_n = ~arm;
            assign net_o  = net_i & pass_n;
        end else begin : g_high
            assign net_o = net_i | arm;
        end
    endgenerate
endmodule

// File: rtl/tp_obs_cell.sv
module tp_obs_cell (
    input  logic tp_en,
    input  logic net_i,
    output logic cap_o
);
    assign cap_o = tp_en & net_i;
endmodule

// File: rtl/tp_bank.sv
module tp_bank
    import tp_bank_pkg::*;
#(
    parameter int N_AND = 2,
    parameter int N_OR  = 2,
    parameter int N_OBS = 3,
    parameter int AW    = (N_AND > 0) ? N_AND : 1,
    parameter int OW    = (N_OR  > 0) ? N_OR  : 1,
    parameter int BW    = (N_OBS > 0) ? N_OBS : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tp_en,
    input  logic          scan_en,
    input  logic          scan_in,
    input  logic [AW-1:0] and_net_i,
    output logic [AW-1:0] and_net_o,
    input  logic [OW-1:0] or_net_i,
    output logic [OW-1:0] or_net_o,
    input  logic [BW-1:0] obs_net_i,
    output logic          scan_out
);
    localparam int NT       = N_AND + N_OR + N_OBS;
    localparam int OR_BASE  = N_AND;
    localparam int OBS_BASE = N_AND + N_OR;

    typedef struct packed {
        logic [NT-1:0] chain;
    } state_t;

    state_t        st_d, st_q;
    logic [NT-1:0] prev_bit;
    logic [NT-1:0] cap_bit;

    // serial neighbour of each chain position
    assign prev_bit[0] = scan_in;
    for (genvar k = 1; k < NT; k++) begin : g_link
        assign prev_bit[k] = st_q.chain[k-1];
    end

    // low-forcing control points
    for (genvar a = 0; a < N_AND; a++) begin : g_and
        tp_ctrl_cell #(.KIND(CP_FORCE_LOW)) u_cell (
            .tp_en (tp_en),
            .hold_q(st_q.chain[a]),
            .net_i (and_net_i[a]),
            .net_o (and_net_o[a])
        );
        assign cap_bit[a] = st_q.chain[a];
    end
    if (N_AND == 0) begin : g_no_and
        assign and_net_o = '0;
    end

    // high-forcing control points
    for (genvar o = 0; o < N_OR; o++) begin : g_or
        tp_ctrl_cell #(.KIND(CP_FORCE_HIGH)) u_cell (
            .tp_en (tp_en),
            .hold_q(st_q.chain[OR_BASE+o]),
            .net_i (or_net_i[o]),
            .net_o (or_net_o[o])
        );
        assign cap_bit[OR_BASE+o] = st_q.chain[OR_BASE+o];
    end
    if (N_OR == 0) begin : g_no_or
        assign or_net_o = '0;
    end

    // observe points
    for (genvar b = 0; b < N_OBS; b++) begin : g_obs
        tp_obs_cell u_cell (
            .tp_en(tp_en),
            .net_i(obs_net_i[b]),
            .cap_o(cap_bit[OBS_BASE+b])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.chain = scan_en ? prev_bit : cap_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scan_out = st_q.chain[NT-1];
endmodule

// File: rtl/tp_bank_chk.sv
module tp_bank_chk #(
    parameter int N_AND = 2,
    parameter int N_OR  = 2,
    parameter int N_OBS = 3,
    parameter int AW    = (N_AND > 0) ? N_AND : 1,
    parameter int OW    = (N_OR  > 0) ? N_OR  : 1,
    parameter int BW    = (N_OBS > 0) ? N_OBS : 1,
    parameter int NT    = N_AND + N_OR + N_OBS
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tp_en,
    input logic          scan_en,
    input logic          scan_in,
    input logic [AW-1:0] and_net_i,
    input logic [AW-1:0] and_net_o,
    input logic [OW-1:0] or_net_i,
    input logic [OW-1:0] or_net_o,
    input logic [BW-1:0] obs_net_i,
    input logic [NT-1:0] chain_q
);
    localparam int OBS_BASE = N_AND + N_OR;

    AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> chain_q[0] == $past(scan_in)); // R6

    for (genvar k = 1; k < NT; k++) begin : g_link_chk
        AST_SHIFT_LINK: assert property (@(posedge clk) disable iff (!rst_n)
            scan_en |=> chain_q[k] == $past(chain_q[k-1])); // R6
    end

    for (genvar a = 0; a < N_AND; a++) begin : g_and_chk
        AST_AND_PASS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !tp_en |-> and_net_o[a] == and_net_i[a]); // R1
        AST_AND_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
            (tp_en && chain_q[a]) |-> !and_net_o[a]); // R2
        AST_AND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !scan_en |=> $stable(chain_q[a])); // R8
    end

    for (genvar o = 0; o < N_OR; o++) begin : g_or_chk
        AST_OR_PASS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !tp_en |-> or_net_o[o] == or_net_i[o]); // R1
        AST_OR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
            (tp_en && chain_q[N_AND+o]) |-> or_net_o[o]); // R3
        AST_OR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !scan_en |=> $stable(chain_q[N_AND+o])); // R8
    end

    for (genvar b = 0; b < N_OBS; b++) begin : g_obs_chk
        AST_OBS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (!scan_en && !tp_en) |=> !chain_q[OBS_BASE+b]); // R4
        AST_OBS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            (!scan_en && tp_en) |=> chain_q[OBS_BASE+b] == $past(obs_net_i[b])); // R5
    end
endmodule

bind tp_bank tp_bank_chk #(
    .N_AND(N_AND),
    .N_OR (N_OR),
    .N_OBS(N_OBS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tp_en    (tp_en),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .and_net_i(and_net_i),
    .and_net_o(and_net_o),
    .or_net_i (or_net_i),
    .or_net_o (or_net_o),
    .obs_net_i(obs_net_i),
    .chain_q  (st_q.chain)
);

// File: tb/tp_bank_bench.sv
`timescale 1ns/1ps
module tp_bank_bench;
    localparam int NA = 2;
    localparam int NO = 2;
    localparam int NB = 3;
    localparam int NT = NA + NO + NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tp_en = 1'b0;
    logic          scan_en = 1'b0;
    logic          scan_in = 1'b0;
    logic [NA-1:0] and_i = '0;
    logic [NA-1:0] and_o;
    logic [NO-1:0] or_i = '0;
    logic [NO-1:0] or_o;
    logic [NB-1:0] obs_i = '0;
    logic          sout;

    logic          scan_en2 = 1'b0;
    logic          scan_in2 = 1'b0;
    logic [1:0]    and_i2 = '0;
    logic [1:0]    and_o2;
    logic          or_o2;
    logic          obs_i2 = 1'b0;
    logic          sout2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tp_bank #(.N_AND(NA), .N_OR(NO), .N_OBS(NB)) u_tp_bank (
        .clk(clk), .rst_n(rst_n), .tp_en(tp_en), .scan_en(scan_en),
        .scan_in(scan_in), .and_net_i(and_i), .and_net_o(and_o),
        .or_net_i(or_i), .or_net_o(or_o), .obs_net_i(obs_i), .scan_out(sout)
    );

    // second configuration: high-forcing group removed
    tp_bank #(.N_AND(2), .N_OR(0), .N_OBS(1)) u_tp_bank_no_or (
        .clk(clk), .rst_n(rst_n), .tp_en(tp_en), .scan_en(scan_en2),
        .scan_in(scan_in2), .and_net_i(and_i2), .and_net_o(and_o2),
        .or_net_i(1'b1), .or_net_o(or_o2), .obs_net_i(obs_i2), .scan_out(sout2)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // first bit shifted ends up in the last position
    task automatic load(input logic [NT-1:0] pat);
        for (int k = NT - 1; k >= 0; k--) begin
            scan_en = 1'b1;
            scan_in = pat[k];
            step();
        end
        scan_en = 1'b0;
        scan_in = 1'b0;
    endtask

    task automatic unload(output logic [NT-1:0] got);
        for (int k = NT - 1; k >= 0; k--) begin
            got[k]  = sout;
            scan_en = 1'b1;
            step();
        end
        scan_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL WDOG actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NT-1:0] got;
        logic [NT-1:0] pat;
        logic [NA-1:0] exp_a;
        logic [NO-1:0] exp_o;

        repeat (3) step();
        rst_n = 1'b1;
        tp_en = 1'b1;
        and_i = 2'b11;
        or_i  = 2'b00;
        #1;
        // R9: reset state, no forcing with enable high
        chk("R9 scan_out after reset", sout, 0);
        chk("R9 and nets pass", and_o, 2'b11);
        chk("R9 or nets pass", or_o, 2'b00);

        // R6 R7: serial round trip and ordering
        pat = 7'b1011001;
        load(pat);
        chk("R7 first bit at scan_out", sout, pat[NT-1]);
        unload(got);
        chk("R6 shift round trip", got, pat);
        pat = 7'b0100110;
        load(pat);
        unload(got);
        chk("R6 shift round trip 2", got, pat);

        // R1 R2 R3: all control patterns x all net values x enable
        for (int p = 0; p < 16; p++) begin
            load({3'b000, 4'(p)});
            for (int n = 0; n < 16; n++) begin
                for (int e = 0; e < 2; e++) begin
                    tp_en = e[0];
                    and_i = n[1:0];
                    or_i  = n[3:2];
                    #1;
                    for (int i = 0; i < NA; i++)
                        exp_a[i] = and_i[i] & ~(tp_en & p[i]);
                    for (int j = 0; j < NO; j++)
                        exp_o[j] = or_i[j] | (tp_en & p[NA+j]);
                    if (e == 0) begin
                        chk("R1 and pass when off", and_o, and_i);
                        chk("R1 or pass when off", or_o, or_i);
                    end else begin
                        chk("R2 low-forcing point", and_o, exp_a);
                        chk("R3 high-forcing point", or_o, exp_o);
                    end
                end
            end
        end

        // R4 R5 R8: capture every observe value at both enables
        for (int v = 0; v < 8; v++) begin
            for (int e = 0; e < 2; e++) begin
                logic [3:0] ctl;
                ctl = 4'((v * 5 + e * 3) % 16);
                load({3'b111, ctl});
                tp_en = e[0];
                obs_i = v[2:0];
                step();
                obs_i = ~v[2:0];
                unload(got);
                chk("R8 control flops held", got[3:0], ctl);
                if (e == 0)
                    chk("R4 observe blocked", got[6:4], 0);
                else
                    chk("R5 observe captured", got[6:4], v[2:0]);
            end
        end

        // R9: asynchronous reset mid-run
        tp_en = 1'b1;
        load(7'b1111111);
        and_i = 2'b11;
        or_i  = 2'b00;
        #1;
        chk("R2 forced before reset", and_o, 2'b00);
        #0.5 rst_n = 1'b0;
        #0.5;
        chk("R9 async clear scan_out", sout, 0);
        chk("R9 async clear and", and_o, 2'b11);
        chk("R9 async clear or", or_o, 2'b00);
        step();
        rst_n = 1'b1;
        step();

        // R10: group removed, chain is AND0, AND1, OBS0
        tp_en  = 1'b1;
        and_i2 = 2'b11;
        scan_en2 = 1'b1;
        scan_in2 = 1'b1; step();
        scan_in2 = 1'b1; step();
        scan_in2 = 1'b0; step();
        scan_en2 = 1'b0;
        #1;
        chk("R10 first bit reaches scan_out after 3 shifts", sout2, 1);
        chk("R10 and group position", and_o2, 2'b01);
        chk("R10 empty group tied low", or_o2, 0);
        obs_i2 = 1'b1;
        step();
        chk("R10 observe is last position", sout2, 1);
        chk("R10 control held", and_o2, 2'b01);
        obs_i2 = 1'b0;
        step();
        chk("R10 observe recapture", sout2, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule